// File: doc/BRIEF.md
# Register Wakeup Scoreboard

This block keeps one ready bit per physical register and a small array of waiting-instruction slots. Register numbers form one index space: integer registers occupy the low indices `0 .. NUM_INT_REGS-1`, and floating-point registers take the indices directly above them. When a register is claimed as the destination of a not-yet-finished producer, its bit is cleared. When that producer's completion is broadcast, the bit is set again.

A dispatching instruction is written into a chosen slot with up to two source register numbers. Each valid source that names a register whose bit is clear becomes a pending operand of that slot. A completion broadcast compares its register number against every pending operand of every occupied slot, so all consumers of that register are released in the same cycle. A slot whose operands are all satisfied shows up in `readyMask`, and the lowest such slot is also presented on `readySlot`. Removing slots (after issue or on a squash) empties them but leaves every register bit alone, because those bits still belong to producers that remain in flight.

Top module: `wake_scoreboard`

## Requirements
- R1: After reset every register bit in `regReady` is 1 and every slot is empty: `readyMask` is all zero and `readyValid` is 0.
- R2: A cycle with `allocValid` clears `regReady[allocTag]` from the next cycle on. Index `i` below `NUM_INT_REGS` is integer register `i`, and index `NUM_INT_REGS+j` is floating-point register `j`. If `wakeValid` names the same index in the same cycle, the clear takes precedence and the bit ends at 0.
- R3: A cycle with `wakeValid` sets `regReady[wakeTag]` from the next cycle on, unless R2 applies to the same index.
- R4: A cycle with `dispValid` fills slot `dispSlot`. `dispSrcValid[0]` qualifies `dispSrc0` and `dispSrcValid[1]` qualifies `dispSrc1`. A valid source whose register bit is 0 becomes pending. Invalid sources and sources whose bit is 1 are already satisfied. The slot is visible in `readyMask` from the next cycle.
- R5: A valid dispatched source that names the register being woken in the same cycle is treated as satisfied. It does not wait for a second broadcast.
- R6: A wakeup satisfies every pending operand that names `wakeTag`, in every occupied slot, in a single cycle. Operands that name other registers stay pending.
- R7: `readyMask[s]` is 1 exactly when slot `s` is occupied and both of its operands are satisfied. `readyValid` is the OR of `readyMask`, and `readySlot` is the lowest index set in `readyMask`.
- R8: `dropMask[s]` empties slot `s` from the next cycle on without changing any `regReady` bit. A later wakeup does not bring a dropped slot back. If a dispatch writes the same slot in that cycle, the dispatch wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Claim a register as a pending destination |
| allocTag | input | TAG_W | Register index being claimed |
| wakeValid | input | 1 | Producer completion broadcast |
| wakeTag | input | TAG_W | Register index that completed |
| dispValid | input | 1 | Write a waiting instruction into a slot |
| dispSlot | input | SLOT_W | Slot being written |
| dispSrcValid | input | 2 | Bit 0 qualifies dispSrc0, bit 1 qualifies dispSrc1 |
| dispSrc0 | input | TAG_W | First source register index |
| dispSrc1 | input | TAG_W | Second source register index |
| dropMask | input | NUM_SLOTS | Slots to empty (issue or squash) |
| readyMask | output | NUM_SLOTS | Per-slot all-operands-ready flags |
| readyValid | output | 1 | At least one slot is ready |
| readySlot | output | SLOT_W | Lowest ready slot index |
| regReady | output | NUM_REGS | Per-register ready bits |

## Verification
The hardest conditions to reach are the same-cycle collisions. They are a dispatch whose source is the register being broadcast, a claim and a broadcast on the same index, and a drop and a dispatch on the same slot. Each needs several inputs to line up in a single cycle, with the register bits already in a known state. The bench builds that state one cycle at a time, using claims followed by dispatches, and then drives the colliding inputs together in one cycle. It also drops a slot that is still pending and then broadcasts the register that slot was waiting on, to show the slot stays empty. It reads `regReady` before and after the drop to show the register bits did not move.

// File: rtl/wake_sb_pkg.sv
package wake_sb_pkg;
  // Per-cycle strobes issued by the control half to the datapath half.
  typedef struct packed {
    logic allocEn;   // clear a register bit
    logic wakeEn;    // broadcast compare against pending operands
    logic sbSetEn;   // broadcast may set the register bit
    logic dispEn;    // a slot is being written
  } sbStrobes_t;
endpackage

// File: rtl/wake_sb_ctrl.sv
module wake_sb_ctrl
  import wake_sb_pkg::*;
#(
  parameter int TAG_W     = 4,
  parameter int NUM_SLOTS = 4,
  parameter int SLOT_W    = 2
) (
  input  logic                 allocValid,
  input  logic [TAG_W-1:0]     allocTag,
  input  logic                 wakeValid,
  input  logic [TAG_W-1:0]     wakeTag,
  input  logic                 dispValid,
  input  logic [SLOT_W-1:0]    dispSlot,
  input  logic [NUM_SLOTS-1:0] dropMask,
  output sbStrobes_t           strobes,
  output logic [NUM_SLOTS-1:0] slotWrite,
  output logic [NUM_SLOTS-1:0] slotDrop
);
  logic sameTag;

  assign sameTag = allocValid && wakeValid && (allocTag == wakeTag);

  always_comb begin
    strobes.allocEn = allocValid;
    strobes.wakeEn  = wakeValid;
    strobes.sbSetEn = wakeValid && !sameTag;   // a claim beats a broadcast
    strobes.dispEn  = dispValid;
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slotDec
    assign slotWrite[s] = dispValid && (dispSlot == SLOT_W'(s));
    assign slotDrop[s]  = dropMask[s] && !slotWrite[s];  // dispatch wins
  end
endmodule

// File: rtl/wake_sb_data.sv
module wake_sb_data
  import wake_sb_pkg::*;
#(
  parameter int NUM_REGS  = 16,
  parameter int TAG_W     = 4,
  parameter int NUM_SLOTS = 4,
  parameter int SLOT_W    = 2,
  localparam int NUM_SRC  = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  sbStrobes_t           strobes,
  input  logic [NUM_SLOTS-1:0] slotWrite,
  input  logic [NUM_SLOTS-1:0] slotDrop,
  input  logic [TAG_W-1:0]     allocTag,
  input  logic [TAG_W-1:0]     wakeTag,
  input  logic [NUM_SRC-1:0]   dispSrcValid,
  input  logic [TAG_W-1:0]     dispSrc0,
  input  logic [TAG_W-1:0]     dispSrc1,
  output logic [NUM_SLOTS-1:0] readyMask,
  output logic                 readyValid,
  output logic [SLOT_W-1:0]    readySlot,
  output logic [NUM_REGS-1:0]  regReady
);
  logic [NUM_REGS-1:0] sbBits;
  logic [TAG_W-1:0]    dispSrc [NUM_SRC];
  logic [NUM_SRC-1:0]  dispRdy;

  assign dispSrc[0] = dispSrc0;
  assign dispSrc[1] = dispSrc1;

  // Register ready bits
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sbBits <= '1;
    end else begin
      for (int r = 0; r < NUM_REGS; r++) begin
        if (strobes.allocEn && allocTag == TAG_W'(r)) begin
          sbBits[r] <= 1'b0;
        end else if (strobes.sbSetEn && wakeTag == TAG_W'(r)) begin
          sbBits[r] <= 1'b1;
        end
      end
    end
  end

  assign regReady = sbBits;

  // Operand readiness at dispatch, including the same-cycle broadcast.
  always_comb begin
    for (int k = 0; k < NUM_SRC; k++) begin
      dispRdy[k] = !dispSrcValid[k] || sbBits[dispSrc[k]] ||
                   (strobes.wakeEn && wakeTag == dispSrc[k]);
    end
  end

  // Waiting slots
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic               entValid;
    logic [NUM_SRC-1:0] opRdy;
    logic [TAG_W-1:0]   opTag [NUM_SRC];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        entValid <= 1'b0;
        opRdy    <= '0;
        for (int k = 0; k < NUM_SRC; k++) opTag[k] <= '0;
      end else if (slotWrite[s] && strobes.dispEn) begin
        entValid <= 1'b1;
        opRdy    <= dispRdy;
        for (int k = 0; k < NUM_SRC; k++) opTag[k] <= dispSrc[k];
      end else if (slotDrop[s]) begin
        entValid <= 1'b0;
        opRdy    <= '0;
      end else if (entValid && strobes.wakeEn) begin
        for (int k = 0; k < NUM_SRC; k++) begin
          if (opTag[k] == wakeTag) opRdy[k] <= 1'b1;
        end
      end
    end

    assign readyMask[s] = entValid && (&opRdy);
  end

  // Lowest ready slot
  always_comb begin
    logic found;
    found     = 1'b0;
    readySlot = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (!found && readyMask[s]) begin
        readySlot = SLOT_W'(s);
        found     = 1'b1;
      end
    end
  end

  assign readyValid = |readyMask;
endmodule

// File: rtl/wake_scoreboard.sv
module wake_scoreboard
  import wake_sb_pkg::*;
#(
  parameter int NUM_INT_REGS = 8,
  parameter int NUM_FP_REGS  = 8,
  parameter int NUM_SLOTS    = 4,
  localparam int NUM_REGS    = NUM_INT_REGS + NUM_FP_REGS,
  localparam int TAG_W       = $clog2(NUM_REGS),
  localparam int SLOT_W      = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 allocValid,
  input  logic [TAG_W-1:0]     allocTag,
  input  logic                 wakeValid,
  input  logic [TAG_W-1:0]     wakeTag,
  input  logic                 dispValid,
  input  logic [SLOT_W-1:0]    dispSlot,
  input  logic [1:0]           dispSrcValid,
  input  logic [TAG_W-1:0]     dispSrc0,
  input  logic [TAG_W-1:0]     dispSrc1,
  input  logic [NUM_SLOTS-1:0] dropMask,
  output logic [NUM_SLOTS-1:0] readyMask,
  output logic                 readyValid,
  output logic [SLOT_W-1:0]    readySlot,
  output logic [NUM_REGS-1:0]  regReady
);
  sbStrobes_t           strobes;
  logic [NUM_SLOTS-1:0] slotWrite;
  logic [NUM_SLOTS-1:0] slotDrop;

  wake_sb_ctrl #(
    .TAG_W(TAG_W), .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)
  ) u_ctrl (
    .allocValid(allocValid), .allocTag(allocTag),
    .wakeValid(wakeValid),   .wakeTag(wakeTag),
    .dispValid(dispValid),   .dispSlot(dispSlot),
    .dropMask(dropMask),
    .strobes(strobes), .slotWrite(slotWrite), .slotDrop(slotDrop)
  );

  wake_sb_data #(
    .NUM_REGS(NUM_REGS), .TAG_W(TAG_W), .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .slotWrite(slotWrite), .slotDrop(slotDrop),
    .allocTag(allocTag), .wakeTag(wakeTag),
    .dispSrcValid(dispSrcValid), .dispSrc0(dispSrc0), .dispSrc1(dispSrc1),
    .readyMask(readyMask), .readyValid(readyValid),
    .readySlot(readySlot), .regReady(regReady)
  );
endmodule

// File: rtl/wake_scoreboard_chk.sv
module wake_scoreboard_chk #(
  parameter int NUM_REGS  = 16,
  parameter int TAG_W     = 4,
  parameter int NUM_SLOTS = 4,
  parameter int SLOT_W    = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 allocValid,
  input logic [TAG_W-1:0]     allocTag,
  input logic                 wakeValid,
  input logic [TAG_W-1:0]     wakeTag,
  input logic                 dispValid,
  input logic [SLOT_W-1:0]    dispSlot,
  input logic [1:0]           dispSrcValid,
  input logic [TAG_W-1:0]     dispSrc0,
  input logic [NUM_SLOTS-1:0] dropMask,
  input logic [NUM_SLOTS-1:0] readyMask,
  input logic                 readyValid,
  input logic [SLOT_W-1:0]    readySlot,
  input logic [NUM_REGS-1:0]  regReady
);
  p_alloc_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    allocValid |=> !regReady[$past(allocTag)]);

  p_wake_sets_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wakeValid && !(allocValid && allocTag == wakeTag)) |=> regReady[$past(wakeTag)]);

  p_nosrc_ready_r4: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid && dispSrcValid == 2'b00) |=> readyMask[$past(dispSlot)]);

  p_bypass_r5: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid && dispSrcValid == 2'b01 && wakeValid && wakeTag == dispSrc0)
      |=> readyMask[$past(dispSlot)]);

  p_lowest_slot_r7: assert property (@(posedge clk) disable iff (!rstN)
    readyValid |-> (readyMask[readySlot] &&
      ((readyMask & ((NUM_SLOTS'(1) << readySlot) - NUM_SLOTS'(1))) == '0)));

  p_drop_keeps_sb_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((|dropMask) && !allocValid && !wakeValid) |=> $stable(regReady));

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_dropChk
    p_drop_empties_r8: assert property (@(posedge clk) disable iff (!rstN)
      (dropMask[s] && !(dispValid && dispSlot == SLOT_W'(s))) |=> !readyMask[s]);
  end
endmodule

bind wake_scoreboard wake_scoreboard_chk #(
  .NUM_REGS(NUM_REGS), .TAG_W(TAG_W), .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .allocValid(allocValid), .allocTag(allocTag),
  .wakeValid(wakeValid), .wakeTag(wakeTag), .dispValid(dispValid),
  .dispSlot(dispSlot), .dispSrcValid(dispSrcValid), .dispSrc0(dispSrc0),
  .dropMask(dropMask), .readyMask(readyMask), .readyValid(readyValid),
  .readySlot(readySlot), .regReady(regReady)
);

// File: tb/wake_scoreboard_test.sv
`timescale 1ns/1ps
module wake_scoreboard_test;
  logic       clk = 1'b0;
  logic       rstN;
  logic       allocValid, wakeValid, dispValid;
  logic [3:0] allocTag, wakeTag, dispSrc0, dispSrc1, dropMask;
  logic [1:0] dispSlot, dispSrcValid;
  logic [3:0] readyMask;
  logic       readyValid;
  logic [1:0] readySlot;
  logic [15:0] regReady;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  wake_scoreboard uut (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .allocTag(allocTag),
    .wakeValid(wakeValid), .wakeTag(wakeTag), .dispValid(dispValid),
    .dispSlot(dispSlot), .dispSrcValid(dispSrcValid), .dispSrc0(dispSrc0),
    .dispSrc1(dispSrc1), .dropMask(dropMask), .readyMask(readyMask),
    .readyValid(readyValid), .readySlot(readySlot), .regReady(regReady)
  );

  typedef struct packed {
    logic       al;  logic [3:0] at;
    logic       wk;  logic [3:0] wt;
    logic       ds;  logic [1:0] sl; logic [1:0] sv;
    logic [3:0] s0;  logic [3:0] s1;
    logic [3:0] drop;
    logic [3:0] expMask;
  } vec_t;

  // R2 R4 R6 R7 R8 walk: claims, dispatches, broadcasts and drops
  localparam vec_t VEC [10] = '{
    '{1'b1, 4'd3,  1'b0, 4'd0,  1'b0, 2'd0, 2'b00, 4'd0, 4'd0,  4'b0000, 4'b0000},
    '{1'b1, 4'd10, 1'b0, 4'd0,  1'b0, 2'd0, 2'b00, 4'd0, 4'd0,  4'b0000, 4'b0000},
    '{1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 2'd0, 2'b01, 4'd3, 4'd0,  4'b0000, 4'b0000},
    '{1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 2'd1, 2'b11, 4'd3, 4'd10, 4'b0000, 4'b0000},
    '{1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 2'd2, 2'b01, 4'd5, 4'd0,  4'b0000, 4'b0100},
    '{1'b0, 4'd0,  1'b1, 4'd3,  1'b0, 2'd0, 2'b00, 4'd0, 4'd0,  4'b0000, 4'b0101},
    '{1'b0, 4'd0,  1'b0, 4'd0,  1'b0, 2'd0, 2'b00, 4'd0, 4'd0,  4'b0101, 4'b0000},
    '{1'b0, 4'd0,  1'b1, 4'd10, 1'b0, 2'd0, 2'b00, 4'd0, 4'd0,  4'b0000, 4'b0010},
    '{1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 2'd3, 2'b00, 4'd0, 4'd0,  4'b0000, 4'b1010},
    '{1'b0, 4'd0,  1'b0, 4'd0,  1'b0, 2'd0, 2'b00, 4'd0, 4'd0,  4'b1010, 4'b0000}
  };

  task automatic idle();
    allocValid = 0; allocTag = 0; wakeValid = 0; wakeTag = 0;
    dispValid = 0; dispSlot = 0; dispSrcValid = 0; dispSrc0 = 0; dispSrc1 = 0;
    dropMask = 0;
  endtask

  // Called at a falling edge; applies inputs for one rising edge and
  // returns at the next falling edge with inputs idle.
  task automatic step(input logic al, input logic [3:0] at, input logic wk,
                      input logic [3:0] wt, input logic ds, input logic [1:0] sl,
                      input logic [1:0] sv, input logic [3:0] s0, input logic [3:0] s1,
                      input logic [3:0] drop);
    allocValid = al; allocTag = at; wakeValid = wk; wakeTag = wt;
    dispValid = ds; dispSlot = sl; dispSrcValid = sv; dispSrc0 = s0; dispSrc1 = s1;
    dropMask = drop;
    @(negedge clk);
    idle();
  endtask

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    idle();
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    check("R1 readyMask", 32'(readyMask), 32'h0);
    check("R1 regReady", 32'(regReady), 32'hFFFF);
    check("R1 readyValid", 32'(readyValid), 32'h0);

    for (int i = 0; i < 10; i++) begin
      step(VEC[i].al, VEC[i].at, VEC[i].wk, VEC[i].wt, VEC[i].ds, VEC[i].sl,
           VEC[i].sv, VEC[i].s0, VEC[i].s1, VEC[i].drop);
      check($sformatf("R6 R7 vector %0d readyMask", i), 32'(readyMask), 32'(VEC[i].expMask));
      if (i == 1) check("R2 int and fp claims", 32'(regReady), 32'hFBF7);
    end
    check("R3 all woken", 32'(regReady), 32'hFFFF);

    // R2 claim, then R5 dispatch with same-cycle wake of that register
    step(1, 4'd4, 0, 0, 0, 0, 0, 0, 0, 0);
    check("R2 claim r4", 32'(regReady), 32'hFFEF);
    step(0, 0, 1, 4'd4, 1, 2'd0, 2'b01, 4'd4, 4'd0, 0);
    check("R5 bypass readyMask", 32'(readyMask), 32'h1);
    check("R3 wake r4", 32'(regReady), 32'hFFFF);
    check("R7 readySlot", 32'(readySlot), 32'h0);
    check("R7 readyValid", 32'(readyValid), 32'h1);

    // R2 claim beats wake on the same index (top fp register 15)
    step(1, 4'd15, 1, 4'd15, 0, 0, 0, 0, 0, 0);
    check("R2 claim precedence", 32'(regReady), 32'h7FFF);

    // R6 one broadcast releases several slots
    step(0, 0, 0, 0, 1, 2'd1, 2'b10, 4'd0, 4'd15, 0);
    step(0, 0, 0, 0, 1, 2'd2, 2'b11, 4'd15, 4'd15, 0);
    check("R4 pending slots", 32'(readyMask), 32'h1);
    step(0, 0, 1, 4'd15, 0, 0, 0, 0, 0, 0);
    check("R6 broadcast readyMask", 32'(readyMask), 32'h7);
    check("R3 wake r15", 32'(regReady), 32'hFFFF);

    // R7 lowest ready slot after dropping slot 0
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 4'b0001);
    check("R7 readyMask", 32'(readyMask), 32'h6);
    check("R7 lowest readySlot", 32'(readySlot), 32'h1);

    // R8 drop leaves register bits; dropped slot not revived
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 4'b0110);
    check("R8 drop empties", 32'(readyMask), 32'h0);
    step(1, 4'd7, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 2'd3, 2'b01, 4'd7, 4'd0, 0);
    check("R4 waits on r7", 32'(readyMask), 32'h0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 4'b1000);
    check("R8 regReady kept", 32'(regReady), 32'hFF7F);
    step(0, 0, 1, 4'd7, 0, 0, 0, 0, 0, 0);
    check("R8 not revived", 32'(readyMask), 32'h0);
    check("R8 readyValid", 32'(readyValid), 32'h0);
    check("R3 wake r7", 32'(regReady), 32'hFFFF);

    // R8 dispatch wins over drop on the same slot
    step(0, 0, 0, 0, 1, 2'd2, 2'b00, 0, 0, 4'b0100);
    check("R8 dispatch wins", 32'(readyMask), 32'h4);
    check("R7 readySlot 2", 32'(readySlot), 32'h2);

    finishRun();
  end
endmodule